// File: doc/BRIEF.md
# Banked Color Lookup Table

This block is the palette stage of a bitplane video pipeline. It stores 256 colors of 12 bits each, one 4-bit field per red, green and blue gun. On every clock it turns a pixel index and a display-mode code into a registered RGB value, one cycle later. Four pixel depths are supported. At 8 bits per pixel all 256 entries are reached directly. At 4 and 2 bits per pixel the table is treated as 16 banks of 16 entries, and a bank register chooses the bank in use. At 1 bit per pixel the two colors come from the top two entries, and an invert flag held inside entry 0 swaps them.

Software reaches the table through three register spaces on one port. The natural space addresses all 256 entries with each gun in plain bit order. The legacy space is a 16-entry window onto the active bank, not a separate store. In that window the bits of every gun field are rotated, so the field's top bit carries the gun's lowest bit. The bank space holds the bank-select register. A single write there recolors everything shown in the banked modes at once.

Top module: `banked_palette`

## Requirements
- R1: While reset is held, rgb_out is 12'h000; after reset the bank register reads 0 (space 2'b10).
- R2: Space 2'b00 (natural) reads and writes entry cpu_addr as the 16-bit word {4'b0, R, G, B} with no bit rotation; bits 15:12 of a write are dropped and read as zero.
- R3: Space 2'b01 (legacy) reaches entry {bank, cpu_addr[3:0]}, with each 4-bit gun field n stored as n = {l[2:0], l[3]} from the legacy field l, and read back as l = {n[0], n[3:1]}.
- R4: Space 2'b10 writes the bank register from cpu_wdata[3:0]; in pix_mode 2'b00 (4 bpp) the lookup index is {bank, pix_idx[3:0]}, so a single bank write changes all 16 displayed colors.
- R5: In pix_mode 2'b11 (8 bpp) the lookup index is pix_idx[7:0], with no bank involvement.
- R6: In pix_mode 2'b01 (2 bpp) the lookup index is {bank, 2'b00, pix_idx[1:0]}.
- R7: In pix_mode 2'b10 (1 bpp) pixel value pix_idx[0]=0 shows entry 254 and pixel value 1 shows entry 255, provided the invert flag is clear.
- R8: The invert flag is bit 1 of natural entry 0. It is therefore reachable in both windows: in the legacy window with bank 0 it is word bit 0, because of the rotation. When the flag is set, the two 1 bpp colors are swapped.
- R9: rgb_out shows the color for the pixel inputs of the previous clock edge. A CPU write to the entry being looked up in that same cycle yields the old color, and the new color appears from the next lookup on.
- R10: Space 2'b11 is reserved: writes change no entry and do not change the bank, and reads return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Write strobe, taken at the rising edge |
| cpu_space | input | 2 | Register space: 00 natural, 01 legacy, 10 bank, 11 reserved |
| cpu_addr | input | 8 | Entry address (natural) or slot in the bank (legacy, low 4 bits) |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the presented space and address (combinational) |
| pix_idx | input | 8 | Pixel color index |
| pix_mode | input | 2 | Depth: 00 4 bpp, 01 2 bpp, 10 1 bpp, 11 8 bpp |
| rgb_out | output | 12 | Registered color {R, G, B} |

## Verification
Two functions can act in the same cycle: a CPU write into the table, and the pixel lookup that reads it, either of one entry directly or through a bank change. The bench drives a natural-space write and an 8 bpp lookup of the same entry on the same falling edge. Its scoreboard expects the old color from that edge and the new color from the following lookup. It also issues a bank write directly after a banked lookup and expects that lookup to still use the previous bank.

// File: rtl/bpal_pkg.sv
package bpal_pkg;

  typedef enum logic [1:0] {
    SP_NATURAL = 2'b00,
    SP_LEGACY  = 2'b01,
    SP_BANK    = 2'b10,
    SP_RSVD    = 2'b11
  } cpu_space_e;

  typedef enum logic [1:0] {
    PM_4BPP = 2'b00,
    PM_2BPP = 2'b01,
    PM_1BPP = 2'b10,
    PM_8BPP = 2'b11
  } pix_mode_e;

  localparam int NUM_GUNS = 3;

endpackage

// File: rtl/bpal_cpu_port.sv
module bpal_cpu_port
  import bpal_pkg::*;
#(
  parameter int GUN_BITS  = 4,
  parameter int BANK_BITS = 4,
  parameter int SLOT_BITS = 4,
  parameter int WORD_W    = 16,
  localparam int IDX_W    = BANK_BITS + SLOT_BITS,
  localparam int COLOR_W  = NUM_GUNS * GUN_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_wr,
  input  logic [1:0]           cpu_space,
  input  logic [IDX_W-1:0]     cpu_addr,
  input  logic [WORD_W-1:0]    cpu_wdata,
  input  logic [COLOR_W-1:0]   rd_color,
  output logic [BANK_BITS-1:0] bank,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     acc_idx,
  output logic [COLOR_W-1:0]   wr_color,
  output logic [WORD_W-1:0]    cpu_rdata
);

  // natural gun -> legacy gun: top bit carries the gun LSB
  function automatic logic [COLOR_W-1:0] to_legacy(input logic [COLOR_W-1:0] c);
    logic [COLOR_W-1:0] r;
    r = '0;
    for (int g = 0; g < NUM_GUNS; g++) begin
      r[g*GUN_BITS +: GUN_BITS] = {c[g*GUN_BITS], c[g*GUN_BITS+1 +: GUN_BITS-1]};
    end
    return r;
  endfunction

  // legacy gun -> natural gun
  function automatic logic [COLOR_W-1:0] from_legacy(input logic [COLOR_W-1:0] l);
    logic [COLOR_W-1:0] r;
    r = '0;
    for (int g = 0; g < NUM_GUNS; g++) begin
      r[g*GUN_BITS +: GUN_BITS] = {l[g*GUN_BITS +: GUN_BITS-1], l[g*GUN_BITS+GUN_BITS-1]};
    end
    return r;
  endfunction

  cpu_space_e sp;
  logic       unused_hi;

  assign sp        = cpu_space_e'(cpu_space);
  assign unused_hi = ^cpu_wdata[WORD_W-1:COLOR_W];

  always_comb begin
    if (sp == SP_LEGACY) acc_idx = {bank, cpu_addr[SLOT_BITS-1:0]};
    else                 acc_idx = cpu_addr;
  end

  assign wr_en = cpu_wr && (sp == SP_NATURAL || sp == SP_LEGACY);

  always_comb begin
    if (sp == SP_LEGACY) wr_color = from_legacy(cpu_wdata[COLOR_W-1:0]);
    else                 wr_color = cpu_wdata[COLOR_W-1:0];
  end

  always_comb begin
    case (sp)
      SP_NATURAL: cpu_rdata = WORD_W'(rd_color);
      SP_LEGACY:  cpu_rdata = WORD_W'(to_legacy(rd_color));
      SP_BANK:    cpu_rdata = WORD_W'(bank);
      default:    cpu_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank <= '0;
    else if (cpu_wr && sp == SP_BANK) bank <= cpu_wdata[BANK_BITS-1:0];
  end

endmodule

// File: rtl/bpal_store.sv
module bpal_store #(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 12,
  parameter int INV_BIT = 1,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   acc_idx,
  input  logic [COLOR_W-1:0] wr_color,
  output logic [COLOR_W-1:0] rd_color,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic [COLOR_W-1:0] rgb_q,
  output logic               invert
);

  logic [COLOR_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[acc_idx] <= wr_color;
  end

  assign rd_color = mem[acc_idx];
  assign invert   = mem[0][INV_BIT];

  // pixel port: read-before-write, so a colliding write shows next cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb_q <= '0;
    else        rgb_q <= mem[lk_idx];
  end

endmodule

// File: rtl/bpal_pixel.sv
module bpal_pixel
  import bpal_pkg::*;
#(
  parameter int BANK_BITS = 4,
  parameter int SLOT_BITS = 4,
  localparam int IDX_W    = BANK_BITS + SLOT_BITS
) (
  input  logic [IDX_W-1:0]     pix_idx,
  input  logic [1:0]           pix_mode,
  input  logic [BANK_BITS-1:0] bank,
  input  logic                 invert,
  output logic [IDX_W-1:0]     lk_idx
);

  function automatic logic [IDX_W-1:0] pixel_index(
    input pix_mode_e              m,
    input logic [IDX_W-1:0]       p,
    input logic [BANK_BITS-1:0]   b,
    input logic                   inv
  );
    case (m)
      PM_8BPP: return p;
      PM_4BPP: return {b, p[SLOT_BITS-1:0]};
      PM_2BPP: return {b, {(SLOT_BITS-2){1'b0}}, p[1:0]};
      default: return {{(IDX_W-1){1'b1}}, p[0] ^ inv};
    endcase
  endfunction

  assign lk_idx = pixel_index(pix_mode_e'(pix_mode), pix_idx, bank, invert);

endmodule

// File: rtl/banked_palette.sv
module banked_palette
  import bpal_pkg::*;
#(
  parameter int GUN_BITS  = 4,
  parameter int BANK_BITS = 4,
  parameter int SLOT_BITS = 4,
  parameter int WORD_W    = 16,
  localparam int IDX_W    = BANK_BITS + SLOT_BITS,
  localparam int COLOR_W  = NUM_GUNS * GUN_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr,
  input  logic [1:0]         cpu_space,
  input  logic [IDX_W-1:0]   cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  output logic [WORD_W-1:0]  cpu_rdata,
  input  logic [IDX_W-1:0]   pix_idx,
  input  logic [1:0]         pix_mode,
  output logic [COLOR_W-1:0] rgb_out
);

  // named internal events, also seen by the bound checker
  logic [BANK_BITS-1:0] bank_q;
  logic                 wr_en;
  logic [IDX_W-1:0]     acc_idx;
  logic [COLOR_W-1:0]   wr_color;
  logic [COLOR_W-1:0]   rd_color;
  logic [IDX_W-1:0]     lk_idx;
  logic                 invert_flag;

  bpal_cpu_port #(
    .GUN_BITS(GUN_BITS), .BANK_BITS(BANK_BITS),
    .SLOT_BITS(SLOT_BITS), .WORD_W(WORD_W)
  ) u_cpu (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_space(cpu_space),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rd_color(rd_color),
    .bank(bank_q), .wr_en(wr_en), .acc_idx(acc_idx),
    .wr_color(wr_color), .cpu_rdata(cpu_rdata)
  );

  bpal_store #(
    .IDX_W(IDX_W), .COLOR_W(COLOR_W), .INV_BIT(1)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_idx(acc_idx),
    .wr_color(wr_color), .rd_color(rd_color), .lk_idx(lk_idx),
    .rgb_q(rgb_out), .invert(invert_flag)
  );

  bpal_pixel #(
    .BANK_BITS(BANK_BITS), .SLOT_BITS(SLOT_BITS)
  ) u_pix (
    .pix_idx(pix_idx), .pix_mode(pix_mode), .bank(bank_q),
    .invert(invert_flag), .lk_idx(lk_idx)
  );

endmodule

// File: rtl/bpal_checker.sv
module bpal_checker #(
  parameter int BANK_BITS = 4,
  parameter int SLOT_BITS = 4,
  parameter int WORD_W    = 16,
  localparam int IDX_W    = BANK_BITS + SLOT_BITS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_wr,
  input logic [1:0]           cpu_space,
  input logic [WORD_W-1:0]    cpu_wdata,
  input logic [WORD_W-1:0]    cpu_rdata,
  input logic [IDX_W-1:0]     pix_idx,
  input logic [1:0]           pix_mode,
  input logic [BANK_BITS-1:0] bank_q,
  input logic                 wr_en,
  input logic [IDX_W-1:0]     acc_idx,
  input logic [IDX_W-1:0]     lk_idx
);

  AST_RDATA_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_space == 2'b00) |-> (cpu_rdata[WORD_W-1:12] == '0)); // R2

  AST_LEGACY_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpu_space == 2'b01) |-> (acc_idx[IDX_W-1:SLOT_BITS] == bank_q)); // R3

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_space == 2'b10) |=> (bank_q == $past(cpu_wdata[BANK_BITS-1:0]))); // R4

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_space == 2'b10) |=> $stable(bank_q)); // R4

  AST_DIRECT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_mode == 2'b11) |-> (lk_idx == pix_idx)); // R5

  AST_QUAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_mode == 2'b01) |-> (lk_idx[IDX_W-1:SLOT_BITS] == bank_q && lk_idx[SLOT_BITS-1:2] == '0)); // R6

  AST_DUO_TOP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_mode == 2'b10) |-> (lk_idx[IDX_W-1:1] == {(IDX_W-1){1'b1}})); // R7

  AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_space == 2'b11) |-> (!wr_en && cpu_rdata == '0)); // R10

endmodule

bind banked_palette bpal_checker #(
  .BANK_BITS(BANK_BITS), .SLOT_BITS(SLOT_BITS), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_space(cpu_space),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pix_idx(pix_idx),
  .pix_mode(pix_mode), .bank_q(bank_q), .wr_en(wr_en),
  .acc_idx(acc_idx), .lk_idx(lk_idx)
);

// File: tb/sim_banked_palette.sv
`timescale 1ns/1ps
module sim_banked_palette;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_space = 2'b00;
  logic [7:0]  cpu_addr = 8'h00;
  logic [15:0] cpu_wdata = 16'h0000;
  logic [15:0] cpu_rdata;
  logic [7:0]  pix_idx = 8'h00;
  logic [1:0]  pix_mode = 2'b11;
  logic [11:0] rgb_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [11:0] ref_pal [256];
  logic [3:0]  ref_bank = 4'h0;
  logic [11:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  banked_palette u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_space(cpu_space),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pix_idx(pix_idx), .pix_mode(pix_mode), .rgb_out(rgb_out)
  );

  // restated rotation, written per gun with shifts
  function automatic logic [3:0] nat2leg(input logic [3:0] n);
    return ((n & 4'h1) << 3) | (n >> 1);
  endfunction
  function automatic logic [3:0] leg2nat(input logic [3:0] l);
    return ((l << 1) & 4'hE) | (l >> 3);
  endfunction
  function automatic logic [11:0] col_to_leg(input logic [11:0] c);
    return {nat2leg(c[11:8]), nat2leg(c[7:4]), nat2leg(c[3:0])};
  endfunction
  function automatic logic [11:0] col_from_leg(input logic [11:0] l);
    return {leg2nat(l[11:8]), leg2nat(l[7:4]), leg2nat(l[3:0])};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] sp, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_space = sp; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
    case (sp)
      2'b00: ref_pal[a] = d[11:0];
      2'b01: ref_pal[{ref_bank, a[3:0]}] = col_from_leg(d[11:0]);
      2'b10: ref_bank = d[3:0];
      default: ;
    endcase
  endtask

  task automatic cpu_read(input logic [1:0] sp, input logic [7:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    cpu_space = sp; cpu_addr = a;
    #1;
    check(tag, cpu_rdata, exp);
  endtask

  // driver: one lookup per cycle, expected color pushed to the scoreboard
  task automatic pix_req(input logic [7:0] p, input logic [1:0] m, input logic [11:0] exp, input string tag);
    @(negedge clk);
    pix_idx = p; pix_mode = m;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor: result of the lookup launched before this edge
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        logic [11:0] e;
        string t;
        #2;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {4'h0, rgb_out}, {4'h0, e});
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] old_c;
    repeat (3) @(negedge clk);
    check("R1 rgb_out in reset", {4'h0, rgb_out}, 16'h0000);
    rst_n = 1'b1;
    cpu_read(2'b10, 8'h00, 16'h0000, "R1 bank after reset");

    for (int i = 0; i < 256; i++)
      cpu_write(2'b00, i[7:0], {4'h0, 12'((i * 12'h2B7 + 12'h15) & 12'hFFF)});
    cpu_write(2'b00, 8'h00, 16'h0000);

    // R2 natural view
    cpu_write(2'b00, 8'h05, 16'hF123);
    cpu_read(2'b00, 8'h05, 16'h0123, "R2 upper bits dropped");
    cpu_read(2'b00, 8'hA7, {4'h0, ref_pal[8'hA7]}, "R2 natural readback");

    // R3 legacy window
    cpu_write(2'b10, 8'h00, 16'h0003);
    cpu_read(2'b01, 8'h07, {4'h0, col_to_leg(ref_pal[8'h37])}, "R3 legacy read rotated");
    cpu_write(2'b01, 8'h02, 16'h09C5);
    cpu_read(2'b00, 8'h32, {4'h0, col_from_leg(12'h9C5)}, "R3 legacy write in natural");
    cpu_read(2'b01, 8'hF2, 16'h09C5, "R3 legacy round trip");

    // R4 banked 4 bpp, bank write recolors all slots
    pix_req(8'hA5, 2'b00, ref_pal[8'h35], "R4 4bpp bank 3");
    cpu_write(2'b10, 8'h00, 16'hFFF9);
    cpu_read(2'b10, 8'h00, 16'h0009, "R4 bank readback");
    for (int s = 0; s < 16; s++)
      pix_req({4'h6, s[3:0]}, 2'b00, ref_pal[{4'h9, s[3:0]}], "R4 4bpp bank 9");

    // R5 direct
    pix_req(8'hC7, 2'b11, ref_pal[8'hC7], "R5 8bpp direct");
    pix_req(8'h13, 2'b11, ref_pal[8'h13], "R5 8bpp direct");

    // R6 2 bpp
    pix_req(8'hFE, 2'b01, ref_pal[8'h92], "R6 2bpp slot 2");
    pix_req(8'h01, 2'b01, ref_pal[8'h91], "R6 2bpp slot 1");

    // R7 duochrome, invert clear
    pix_req(8'h00, 2'b10, ref_pal[254], "R7 1bpp pixel 0");
    pix_req(8'h01, 2'b10, ref_pal[255], "R7 1bpp pixel 1");
    pix_req(8'hFE, 2'b10, ref_pal[254], "R7 1bpp pixel 0 high bits");

    // R8 invert via legacy window bank 0 (word bit 0 = natural bit 1)
    cpu_write(2'b10, 8'h00, 16'h0000);
    cpu_write(2'b01, 8'h00, 16'h0001);
    cpu_read(2'b00, 8'h00, 16'h0002, "R8 invert at natural bit 1");
    pix_req(8'h00, 2'b10, ref_pal[255], "R8 inverted pixel 0");
    pix_req(8'h01, 2'b10, ref_pal[254], "R8 inverted pixel 1");
    cpu_write(2'b00, 8'h00, 16'h0000);
    pix_req(8'h00, 2'b10, ref_pal[254], "R8 invert cleared");

    // R9 collision: write and lookup of one entry in the same cycle
    old_c = ref_pal[8'h40];
    @(negedge clk);
    cpu_wr = 1'b1; cpu_space = 2'b00; cpu_addr = 8'h40; cpu_wdata = 16'h0ABC;
    pix_idx = 8'h40; pix_mode = 2'b11;
    exp_q.push_back(old_c); tag_q.push_back("R9 same cycle old color");
    @(negedge clk);
    cpu_wr = 1'b0;
    exp_q.push_back(12'hABC); tag_q.push_back("R9 next cycle new color");
    ref_pal[8'h40] = 12'hABC;

    // R10 reserved space
    cpu_write(2'b11, 8'h10, 16'h0777);
    cpu_read(2'b11, 8'h10, 16'h0000, "R10 reserved reads zero");
    cpu_read(2'b00, 8'h10, {4'h0, ref_pal[8'h10]}, "R10 entry untouched");
    cpu_read(2'b10, 8'h00, 16'h0000, "R10 bank untouched");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule